// File: doc/BRIEF.md
# Content-Addressable Memory Host Port Cycle Decoder

This block sits between the host bus and the internals of a content-addressable memory. On every clock it classifies the bus cycle from three active-low strobes (enable, command/data select, write/read select) as idle, command write, command read, data write or data read. It then acts on it. Command writes either pass an instruction word to the instruction decoder or carry a transfer opcode. A transfer opcode loads one of five 16-bit control registers, or arms a register readback for the following command read. Data cycles go to a persistent destination (writes) or a persistent source (reads). Each is the comparand, one of two mask registers, or the memory array. Array accesses are not performed here; they leave the block as request strobes with an access mode.

Device-select gating decides whether the device takes part in a cycle. The device is selected when its device-select register equals its page-address register. An all-ones device-select lets writes through but suppresses all reads. A load of the device-select register is accepted in every case. The controller has two states. ST_IDLE is the resting state. ST_PEND is entered by the transition ARM, an accepted transfer opcode with its direction flag at 0. It is left after exactly one cycle by the transition CONSUME_OR_DROP, whatever that cycle is. The only exception is a cycle that arms again (transition RE_ARM).

Top module: `cam_host_port`

## Requirements
- R1: With en_n low, {cmd_n,wr_n} = 00 is a command write, 01 a command read, 10 a data write and 11 a data read. dq_oe is high only during a read cycle of a device allowed to read, and is low in the same cycle that en_n is high.
- R2: A command write whose bits 31:28 are neither 0xA, 0x5 nor 0x6 raises instr_valid in that cycle, with instr_code equal to dq_in.
- R3: A command write with bits 31:28 = 0xA and bit 27 = 1 loads dq_in[15:0] into the register picked by bits 26:24. The codes are 0 address, 1 control, 2 page address, 3 segment control and 4 device select.
- R4: A command write with bits 31:28 = 0xA and bit 27 = 0, followed at once by a command read, returns the picked register on dq_out[15:0] and status_in[31:16] on dq_out[31:16]. For the page-address register the upper half is zero.
- R5: The armed readback lasts one cycle only. Any other cycle in between, idle included, makes the next command read return status_in.
- R6: A command read with no armed readback returns the full 32-bit status_in.
- R7: After reset the comparand is both the data-write destination and the data-read source.
- R8: Bits 31:28 = 0x5 select the source and 0x6 the destination, using target code dq_in[2:0]: 0 comparand, 1 mask 1, 2 mask 2, 3 array at address, 4 array at next free (destination only), 5 array at highest-priority match. Array targets raise arr_wr_req or arr_rd_req, with arr_mode 0, 1 or 2 for codes 3, 4 and 5; a read returns arr_rdata. Invalid codes leave the selection unchanged.
- R9: When device select differs from page address, reads are not driven and writes have no effect. A load of device select (bits 31:24 = 0xAC) is still accepted.
- R10: With device select = 0xFFFF, writes take effect but no read drives dq_oe.
- R11: Readback codes 5 and 6 return the source and destination target codes in bits 2:0. For code 5, bits 15:8 carry the device ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low cycle enable |
| cmd_n | input | 1 | Low for command cycles, high for data cycles |
| wr_n | input | 1 | Low for write, high for read |
| dq_in | input | DATA_W | Bus input data |
| status_in | input | DATA_W | Status word from the device core |
| arr_rdata | input | DATA_W | Data returned by the memory array |
| dq_out | output | DATA_W | Bus output data |
| dq_oe | output | 1 | Bus output enable |
| instr_valid | output | 1 | Instruction strobe to the instruction decoder |
| instr_code | output | DATA_W | Instruction word |
| arr_wr_req | output | 1 | Array write request |
| arr_rd_req | output | 1 | Array read request |
| arr_mode | output | 2 | Array access mode: 0 address, 1 next free, 2 highest match |
| arr_addr | output | REG_W | Address register value for array accesses |

## Verification
The cycle decode is tried with all four strobe combinations plus idle. Instruction words and the three special opcodes are mixed, so that a misread opcode field shows up as a wrong strobe. Readbacks of the control, page-address and selector registers tell the status-upper-half path apart from the zeroed page case and from the device-ID field. Armed readbacks are broken by idle cycles and by instruction writes, which separates one-cycle persistence from longer persistence. Matched, mismatched and all-ones device-select settings separate read gating from write gating.

// File: rtl/cam_host_pkg.sv
package cam_host_pkg;

    typedef enum logic [2:0] {
        CY_IDLE,
        CY_CMD_WR,
        CY_CMD_RD,
        CY_DAT_WR,
        CY_DAT_RD
    } cyc_e;

    typedef enum logic [1:0] {
        OP_INSTR,
        OP_XFER,
        OP_SEL_SRC,
        OP_SEL_DST
    } op_e;

    typedef enum logic {
        ST_IDLE,
        ST_PEND
    } st_e;

    localparam logic [3:0] OPC_XFER    = 4'hA;
    localparam logic [3:0] OPC_SEL_SRC = 4'h5;
    localparam logic [3:0] OPC_SEL_DST = 4'h6;

    localparam logic [2:0] RS_ADDR   = 3'd0;
    localparam logic [2:0] RS_CTRL   = 3'd1;
    localparam logic [2:0] RS_PAGE   = 3'd2;
    localparam logic [2:0] RS_SEG    = 3'd3;
    localparam logic [2:0] RS_DEVSEL = 3'd4;
    localparam logic [2:0] RS_SRC_RB = 3'd5;
    localparam logic [2:0] RS_DST_RB = 3'd6;

    localparam logic [2:0] TG_CMP       = 3'd0;
    localparam logic [2:0] TG_MK1       = 3'd1;
    localparam logic [2:0] TG_MK2       = 3'd2;
    localparam logic [2:0] TG_ARR_ADDR  = 3'd3;
    localparam logic [2:0] TG_ARR_FREE  = 3'd4;
    localparam logic [2:0] TG_ARR_MATCH = 3'd5;

    localparam int NUM_CREGS = 5;
    localparam int NUM_DREGS = 3;

    function automatic logic [1:0] arr_mode_of(input logic [2:0] code);
        case (code)
            TG_ARR_ADDR: return 2'd0;
            TG_ARR_FREE: return 2'd1;
            default:     return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/cam_cycle_decode.sv
module cam_cycle_decode
    import cam_host_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             en_n,
    input  logic             cmd_n,
    input  logic             wr_n,
    input  logic [7:0]       hdr,
    input  logic [REG_W-1:0] devsel,
    input  logic [REG_W-1:0] page,
    output cyc_e             cyc,
    output op_e              op,
    output logic             xfer_dir,
    output logic [2:0]       xfer_sel,
    output logic             wr_ok,
    output logic             rd_ok
);

    logic bcast;
    logic match;

    always_comb begin
        bcast = &devsel;
        match = (devsel == page);
        wr_ok = match | bcast;
        rd_ok = match & ~bcast;
    end

    always_comb begin
        if (en_n) begin
            cyc = CY_IDLE;
        end else begin
            unique case ({cmd_n, wr_n})
                2'b00:   cyc = CY_CMD_WR;
                2'b01:   cyc = CY_CMD_RD;
                2'b10:   cyc = CY_DAT_WR;
                default: cyc = CY_DAT_RD;
            endcase
        end
    end

    always_comb begin
        case (hdr[7:4])
            OPC_XFER:    op = OP_XFER;
            OPC_SEL_SRC: op = OP_SEL_SRC;
            OPC_SEL_DST: op = OP_SEL_DST;
            default:     op = OP_INSTR;
        endcase
        xfer_dir = hdr[3];
        xfer_sel = hdr[2:0];
    end

endmodule

// File: rtl/cam_reg_file.sv
module cam_reg_file
    import cam_host_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ld_en,
    input  logic [2:0]                         ld_sel,
    input  logic [REG_W-1:0]                   ld_val,
    input  logic                               sel_src_en,
    input  logic                               sel_dst_en,
    input  logic [2:0]                         tgt_code,
    input  logic                               dat_en,
    input  logic [DATA_W-1:0]                  dat_val,
    output logic [NUM_CREGS-1:0][REG_W-1:0]    cregs,
    output logic [NUM_DREGS-1:0][DATA_W-1:0]   dregs,
    output logic [2:0]                         src_code,
    output logic [2:0]                         dst_code
);

    logic src_valid;
    logic dst_valid;

    always_comb begin
        dst_valid = (tgt_code <= TG_ARR_MATCH);
        src_valid = dst_valid && (tgt_code != TG_ARR_FREE);
    end

    for (genvar i = 0; i < NUM_CREGS; i++) begin : g_creg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cregs[i] <= '0;
            end else if (ld_en && ld_sel == 3'(i)) begin
                cregs[i] <= ld_val;
            end
        end
    end

    for (genvar j = 0; j < NUM_DREGS; j++) begin : g_dreg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dregs[j] <= '0;
            end else if (dat_en && dst_code == 3'(j)) begin
                dregs[j] <= dat_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_code <= TG_CMP;
            dst_code <= TG_CMP;
        end else begin
            if (sel_src_en && src_valid) src_code <= tgt_code;
            if (sel_dst_en && dst_valid) dst_code <= tgt_code;
        end
    end

endmodule

// File: rtl/cam_read_mux.sv
module cam_read_mux
    import cam_host_pkg::*;
#(
    parameter int         REG_W  = 16,
    parameter int         DATA_W = 32,
    parameter logic [7:0] DEV_ID = 8'h3C
) (
    input  cyc_e                              cyc,
    input  logic                              pend,
    input  logic [2:0]                        pend_sel,
    input  logic [NUM_CREGS-1:0][REG_W-1:0]   cregs,
    input  logic [NUM_DREGS-1:0][DATA_W-1:0]  dregs,
    input  logic [2:0]                        src_code,
    input  logic [2:0]                        dst_code,
    input  logic [DATA_W-1:0]                 status,
    input  logic [DATA_W-1:0]                 arr_rdata,
    output logic [DATA_W-1:0]                 rdata
);

    localparam int HI_W = DATA_W - REG_W;

    logic [HI_W-1:0]  st_hi;
    logic [REG_W-1:0] lo;

    always_comb begin
        st_hi = status[DATA_W-1:REG_W];
        lo    = '0;
        rdata = '0;
        unique case (pend_sel)
            RS_ADDR:   lo = cregs[0];
            RS_CTRL:   lo = cregs[1];
            RS_PAGE:   lo = cregs[2];
            RS_SEG:    lo = cregs[3];
            RS_DEVSEL: lo = cregs[4];
            RS_SRC_RB: lo = REG_W'({DEV_ID, 5'b0, src_code});
            RS_DST_RB: lo = REG_W'({8'h00, 5'b0, dst_code});
            default:   lo = '0;
        endcase
        if (cyc == CY_CMD_RD) begin
            if (!pend) begin
                rdata = status;
            end else if (pend_sel == RS_PAGE) begin
                rdata = {{HI_W{1'b0}}, lo};
            end else begin
                rdata = {st_hi, lo};
            end
        end else if (cyc == CY_DAT_RD) begin
            if (src_code == TG_CMP)      rdata = dregs[0];
            else if (src_code == TG_MK1) rdata = dregs[1];
            else if (src_code == TG_MK2) rdata = dregs[2];
            else                         rdata = arr_rdata;
        end
    end

endmodule

// File: rtl/cam_host_port.sv
module cam_host_port
    import cam_host_pkg::*;
#(
    parameter int         DATA_W = 32,
    parameter int         REG_W  = 16,
    parameter logic [7:0] DEV_ID = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              cmd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              instr_valid,
    output logic [DATA_W-1:0] instr_code,
    output logic              arr_wr_req,
    output logic              arr_rd_req,
    output logic [1:0]        arr_mode,
    output logic [REG_W-1:0]  arr_addr
);

    cyc_e       cyc;
    op_e        op;
    logic       xfer_dir;
    logic [2:0] xfer_sel;
    logic       wr_ok;
    logic       rd_ok;

    st_e        state_q;
    st_e        state_d;
    logic [2:0] pend_sel_q;
    logic       rd_arm;
    logic       rd_pend;

    logic       ld_en;
    logic       sel_src_en;
    logic       sel_dst_en;
    logic       dat_en;

    logic [NUM_CREGS-1:0][REG_W-1:0]  cregs;
    logic [NUM_DREGS-1:0][DATA_W-1:0] dregs;
    logic [2:0]                       src_code;
    logic [2:0]                       dst_code;
    logic [DATA_W-1:0]                rdata;
    logic [REG_W-1:0]                 devsel_w;
    logic [REG_W-1:0]                 page_w;

    assign devsel_w = cregs[RS_DEVSEL];
    assign page_w   = cregs[RS_PAGE];
    assign arr_addr = cregs[RS_ADDR];
    assign rd_pend  = (state_q == ST_PEND);

    cam_cycle_decode #(.REG_W(REG_W)) u_dec (
        .en_n     (en_n),
        .cmd_n    (cmd_n),
        .wr_n     (wr_n),
        .hdr      (dq_in[DATA_W-1:DATA_W-8]),
        .devsel   (devsel_w),
        .page     (page_w),
        .cyc      (cyc),
        .op       (op),
        .xfer_dir (xfer_dir),
        .xfer_sel (xfer_sel),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_sel_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_arm) pend_sel_q <= xfer_sel;
        end
    end

    // next state: ARM, RE_ARM, CONSUME_OR_DROP
    always_comb begin
        rd_arm = (cyc == CY_CMD_WR) && wr_ok && (op == OP_XFER) && !xfer_dir;
        unique case (state_q)
            ST_IDLE: state_d = rd_arm ? ST_PEND : ST_IDLE;
            ST_PEND: state_d = rd_arm ? ST_PEND : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        ld_en       = (cyc == CY_CMD_WR) && (op == OP_XFER) && xfer_dir
                      && (xfer_sel <= RS_DEVSEL)
                      && (wr_ok || xfer_sel == RS_DEVSEL);
        sel_src_en  = (cyc == CY_CMD_WR) && wr_ok && (op == OP_SEL_SRC);
        sel_dst_en  = (cyc == CY_CMD_WR) && wr_ok && (op == OP_SEL_DST);
        instr_valid = (cyc == CY_CMD_WR) && wr_ok && (op == OP_INSTR);
        instr_code  = dq_in;
        dat_en      = (cyc == CY_DAT_WR) && wr_ok && (dst_code < TG_ARR_ADDR);
        arr_wr_req  = (cyc == CY_DAT_WR) && wr_ok && (dst_code >= TG_ARR_ADDR);
        arr_rd_req  = (cyc == CY_DAT_RD) && rd_ok && (src_code >= TG_ARR_ADDR);
        arr_mode    = arr_wr_req ? arr_mode_of(dst_code) : arr_mode_of(src_code);
        dq_oe       = ((cyc == CY_CMD_RD) || (cyc == CY_DAT_RD)) && rd_ok;
        dq_out      = dq_oe ? rdata : '0;
    end

    cam_reg_file #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_sel     (xfer_sel),
        .ld_val     (dq_in[REG_W-1:0]),
        .sel_src_en (sel_src_en),
        .sel_dst_en (sel_dst_en),
        .tgt_code   (dq_in[2:0]),
        .dat_en     (dat_en),
        .dat_val    (dq_in),
        .cregs      (cregs),
        .dregs      (dregs),
        .src_code   (src_code),
        .dst_code   (dst_code)
    );

    cam_read_mux #(.REG_W(REG_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_rmux (
        .cyc       (cyc),
        .pend      (rd_pend),
        .pend_sel  (pend_sel_q),
        .cregs     (cregs),
        .dregs     (dregs),
        .src_code  (src_code),
        .dst_code  (dst_code),
        .status    (status_in),
        .arr_rdata (arr_rdata),
        .rdata     (rdata)
    );

endmodule

// File: rtl/cam_host_port_chk.sv
module cam_host_port_chk #(
    parameter int DATA_W = 32,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_n,
    input logic              cmd_n,
    input logic              wr_n,
    input logic [DATA_W-1:0] dq_in,
    input logic              dq_oe,
    input logic              instr_valid,
    input logic              arr_wr_req,
    input logic              arr_rd_req,
    input logic [REG_W-1:0]  devsel,
    input logic [REG_W-1:0]  page,
    input logic              pend
);

    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!en_n && wr_n)); // R1

    AST_INSTR_ON_CMD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> (!en_n && !cmd_n && !wr_n)); // R2

    AST_PEND_AFTER_CMD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> $past(!en_n && !cmd_n && !wr_n)); // R5

    AST_ARR_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_wr_req, arr_rd_req})); // R8

    AST_NO_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel != page) |-> !dq_oe); // R9

    AST_DEVSEL_LOAD_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !cmd_n && !wr_n && dq_in[DATA_W-1:DATA_W-8] == 8'hAC)
        |=> (devsel == $past(dq_in[REG_W-1:0]))); // R9

    AST_BCAST_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (&devsel) |-> !dq_oe); // R10

endmodule

bind cam_host_port cam_host_port_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_n        (en_n),
    .cmd_n       (cmd_n),
    .wr_n        (wr_n),
    .dq_in       (dq_in),
    .dq_oe       (dq_oe),
    .instr_valid (instr_valid),
    .arr_wr_req  (arr_wr_req),
    .arr_rd_req  (arr_rd_req),
    .devsel      (devsel_w),
    .page        (page_w),
    .pend        (rd_pend)
);

// File: tb/tb_cam_host_port.sv
`timescale 1ns/1ps
module tb_cam_host_port;

    typedef struct packed {
        logic        oe;
        logic [31:0] data;
        logic        iv;
        logic        aw;
        logic        ar;
        logic [1:0]  mode;
    } exp_t;

    localparam logic [31:0] STAT = 32'hDEAD_BEEF;
    localparam logic [31:0] ARRD = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_n = 1'b1;
    logic        cmd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [31:0] dq_in = '0;
    logic [31:0] status_in = STAT;
    logic [31:0] arr_rdata = ARRD;
    logic [31:0] dq_out;
    logic        dq_oe;
    logic        instr_valid;
    logic [31:0] instr_code;
    logic        arr_wr_req;
    logic        arr_rd_req;
    logic [1:0]  arr_mode;
    logic [15:0] arr_addr;

    logic chk = 1'b0;
    bit   done = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    cam_host_port dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .cmd_n(cmd_n), .wr_n(wr_n),
        .dq_in(dq_in), .status_in(status_in), .arr_rdata(arr_rdata),
        .dq_out(dq_out), .dq_oe(dq_oe), .instr_valid(instr_valid),
        .instr_code(instr_code), .arr_wr_req(arr_wr_req), .arr_rd_req(arr_rd_req),
        .arr_mode(arr_mode), .arr_addr(arr_addr)
    );

    function automatic exp_t mk(logic oe, logic [31:0] d, logic iv, logic aw, logic ar, logic [1:0] m);
        exp_t e;
        e.oe = oe; e.data = d; e.iv = iv; e.aw = aw; e.ar = ar; e.mode = m;
        return e;
    endfunction

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        if (chk && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            bit    bad;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            bad = (dq_oe !== e.oe) || (e.oe && dq_out !== e.data) ||
                  (instr_valid !== e.iv) || (arr_wr_req !== e.aw) ||
                  (arr_rd_req !== e.ar) ||
                  ((e.aw || e.ar) && arr_mode !== e.mode) ||
                  (e.iv && instr_code !== dq_in);
            n_chk++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: got oe=%b data=%h iv=%b aw=%b ar=%b mode=%0d exp oe=%b data=%h iv=%b aw=%b ar=%b mode=%0d",
                         t, dq_oe, dq_out, instr_valid, arr_wr_req, arr_rd_req, arr_mode,
                         e.oe, e.data, e.iv, e.aw, e.ar, e.mode);
            end
        end
    end

    // driver
    task automatic drive(input logic e, input logic c, input logic w, input logic [31:0] d,
                         input bit chk_en, input exp_t ex, input string tag);
        @(posedge clk);
        #1;
        en_n = e; cmd_n = c; wr_n = w; dq_in = d; chk = chk_en;
        if (chk_en) begin
            exp_q.push_back(ex);
            tag_q.push_back(tag);
        end
    endtask

    task automatic cmdw(input logic [31:0] d);
        drive(1'b0, 1'b0, 1'b0, d, 1'b0, '0, "");
    endtask
    task automatic cmdw_iv(input logic [31:0] d, input logic iv, input string tag);
        drive(1'b0, 1'b0, 1'b0, d, 1'b1, mk(1'b0, '0, iv, 1'b0, 1'b0, 2'd0), tag);
    endtask
    task automatic cmdr(input logic oe, input logic [31:0] d, input string tag);
        drive(1'b0, 1'b0, 1'b1, '0, 1'b1, mk(oe, d, 1'b0, 1'b0, 1'b0, 2'd0), tag);
    endtask
    task automatic datw(input logic [31:0] d, input logic aw, input logic [1:0] m, input string tag);
        drive(1'b0, 1'b1, 1'b0, d, 1'b1, mk(1'b0, '0, 1'b0, aw, 1'b0, m), tag);
    endtask
    task automatic datr(input logic oe, input logic [31:0] d, input logic ar, input logic [1:0] m, input string tag);
        drive(1'b0, 1'b1, 1'b1, '0, 1'b1, mk(oe, d, 1'b0, 1'b0, ar, m), tag);
    endtask
    task automatic idle(input bit c, input string tag);
        drive(1'b1, 1'b1, 1'b1, '0, c, mk(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'd0), tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1, "R1 reset idle no drive");
        cmdr(1, STAT, "R6 default command read");
        idle(1, "R1 oe drops when enable high");
        datw(32'hCAFE_F00D, 0, 2'd0, "R7 write default destination");
        datr(1, 32'hCAFE_F00D, 0, 2'd0, "R7 read default source");
        cmdw_iv(32'h0000_0123, 1, "R2 instruction strobe");
        // load and read back address
        cmdw_iv(32'hA800_0055, 0, "R3 load address no instr");
        cmdw(32'hA000_0000);
        cmdr(1, {STAT[31:16], 16'h0055}, "R4 readback address");
        cmdw(32'hA900_1111);
        cmdw(32'hA100_0000);
        cmdr(1, {STAT[31:16], 16'h1111}, "R3 R4 readback control");
        cmdw(32'hAB00_0ABC);
        cmdw(32'hA300_0000);
        cmdr(1, {STAT[31:16], 16'h0ABC}, "R3 readback segment");
        // page then device select so the device stays selected
        cmdw(32'hAA00_0007);
        cmdw(32'hAC00_0007);
        cmdw(32'hA200_0000);
        cmdr(1, 32'h0000_0007, "R4 page readback upper zero");
        cmdw(32'hA400_0000);
        cmdr(1, {STAT[31:16], 16'h0007}, "R3 readback device select");
        cmdr(1, STAT, "R5 second read returns status");
        // pending cleared
        cmdw(32'hA100_0000);
        idle(0, "");
        cmdr(1, STAT, "R5 idle clears pending");
        cmdw(32'hA100_0000);
        cmdw_iv(32'h0000_0456, 1, "R2 instr between arm and read");
        cmdr(1, STAT, "R5 instr clears pending");
        // persistent selectors
        cmdw(32'h5000_0001);
        cmdw(32'h6000_0001);
        datw(32'h0F0F_0F0F, 0, 2'd0, "R8 write mask1");
        datr(1, 32'h0F0F_0F0F, 0, 2'd0, "R8 read mask1");
        cmdw(32'h6000_0002);
        datw(32'h3C3C_3C3C, 0, 2'd0, "R8 write mask2");
        cmdw(32'h5000_0002);
        datr(1, 32'h3C3C_3C3C, 0, 2'd0, "R8 read mask2");
        cmdw(32'h5000_0000);
        datr(1, 32'hCAFE_F00D, 0, 2'd0, "R8 restore comparand source");
        cmdw(32'h6000_0003);
        datw(32'h0000_0001, 1, 2'd0, "R8 array write at address");
        cmdw(32'h6000_0004);
        datw(32'h0000_0002, 1, 2'd1, "R8 array write next free");
        cmdw(32'h5000_0005);
        datr(1, ARRD, 1, 2'd2, "R8 array read highest match");
        cmdw(32'h5000_0004);
        datr(1, ARRD, 1, 2'd2, "R8 next free source ignored");
        cmdw(32'hA500_0000);
        cmdr(1, {STAT[31:16], 8'h3C, 8'h05}, "R11 source readback with id");
        cmdw(32'hA600_0000);
        cmdr(1, {STAT[31:16], 16'h0004}, "R11 destination readback");
        cmdw(32'h5000_0000);
        cmdw(32'h6000_0000);
        // deselect
        cmdw(32'hAC00_0001);
        cmdr(0, '0, "R9 deselected no read drive");
        datr(0, '0, 0, 2'd0, "R9 deselected data read");
        cmdw_iv(32'h0000_0777, 0, "R9 deselected instr blocked");
        datw(32'h1111_1111, 0, 2'd0, "R9 deselected write issued");
        cmdw(32'hAC00_0007);
        cmdr(1, STAT, "R9 devsel load accepted while deselected");
        datr(1, 32'hCAFE_F00D, 0, 2'd0, "R9 deselected write had no effect");
        // broadcast
        cmdw(32'hAC00_FFFF);
        cmdr(0, '0, "R10 broadcast no command read");
        datr(0, '0, 0, 2'd0, "R10 broadcast no data read");
        cmdw_iv(32'h0000_0888, 1, "R10 broadcast instr accepted");
        datw(32'h2222_2222, 0, 2'd0, "R10 broadcast data write");
        cmdw(32'hAC00_0007);
        datr(1, 32'h2222_2222, 0, 2'd0, "R10 broadcast write took effect");
        idle(1, "R1 final idle");
        idle(0, "");
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule